// File: doc/BRIEF.md
# DDS Phase Accumulator and Wave Shaper

This block is the numerically controlled oscillator at the heart of a direct digital synthesizer. It holds no registers for software. It receives two frequency tuning words and two phase offsets as plain inputs. On every enabled clock it adds the selected tuning word to a phase accumulator. It then adds the selected offset to the top bits of that accumulator and truncates the sum to a short phase word. That phase word becomes a 10-bit offset-binary code for a digital-to-analog converter. The code is either a sine, taken from a quarter-wave table built when the design is elaborated, or a linear triangle. The most significant bit of the code can also be driven on a one-bit square output, either directly or divided by two.

Two control inputs hold the oscillator still. The clear input zeroes the accumulator and parks the output at midscale. The tuning and offset inputs are untouched and stay in force. The sleep input freezes every pipeline stage, so the output holds its current value. Inputs changed during sleep only show up after the block wakes, with the normal latency.

The output is a continuous sample stream with one sample per enabled clock. It has no valid/ready handshake because there is no consumer that can push back: the converter takes every code. Sleep is the only stall. All control pins are plain levels that are sampled on the rising clock edge.

Top module: `dds_nco_core`

## Requirements
- R1: On every clock with sleep low, the 28-bit accumulator advances by `freq_a_i` when `freq_sel_i`=0 or by `freq_b_i` when `freq_sel_i`=1, and wraps modulo 2^28. The word sampled on an edge already counts in the phase of that edge's sample.
- R2: The 12-bit phase is accumulator bits [27:16] plus `ofs_a_i` (`ofs_sel_i`=0) or `ofs_b_i` (`ofs_sel_i`=1), modulo 4096.
- R3: With `tri_mode_i`=1 the code is a triangle. If phase bit 11 is set, phase bits [10:0] are inverted. Bits [10:1] of that result are the code.
- R4: With `tri_mode_i`=0 the code is a sine. Let k be phase bits [9:0], inverted when phase bit 10 is set. The magnitude m is within 2 LSB of 511·sin(π/2·k/1024), and m is exactly 0 when k=0. The code is 512+m when phase bit 11 is clear and 512−m when it is set.
- R5: The latency from input to output is a constant 8 enabled clocks. Inputs sampled on enabled edge e set the outputs that appear after enabled edge e+7.
- R6: A sample taken with `acc_clear_i`=1 zeroes the accumulator, gives the code 512 and drives `sq_o` low. The first sample after release appears 8 clocks later and carries the selected tuning word.
- R7: While `clk_sleep_i`=1 no stage advances and both outputs hold. Input changes made during sleep take effect only on the clocks after wake-up.
- R8: With `bit_out_i`=1, `tri_mode_i`=0 and `msb_direct_i`=1, `sq_o` equals bit 9 of the sample's code.
- R9: With `bit_out_i`=1, `tri_mode_i`=0 and `msb_direct_i`=0, `sq_o` is a toggle. It flips on each sample whose code bit 9 is 1 when the previous sample's bit 9 was 0, and it returns to 0 on any cleared sample.
- R10: `sq_o` is 0 for any sample with `bit_out_i`=0, and for the reserved combination `bit_out_i`=1 with `tri_mode_i`=1.
- R11: While `rst_n` is low, `dac_code_o` is 512 and `sq_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | master clock |
| rst_n | input | 1 | asynchronous active-low reset |
| freq_a_i | input | 28 | tuning word of bank 0 |
| freq_b_i | input | 28 | tuning word of bank 1 |
| ofs_a_i | input | 12 | phase offset of bank 0 |
| ofs_b_i | input | 12 | phase offset of bank 1 |
| freq_sel_i | input | 1 | picks the tuning word (0: bank 0) |
| ofs_sel_i | input | 1 | picks the phase offset (0: bank 0) |
| acc_clear_i | input | 1 | holds the accumulator at zero and the output at midscale |
| clk_sleep_i | input | 1 | freezes all stages |
| tri_mode_i | input | 1 | 1: triangle, 0: sine |
| bit_out_i | input | 1 | enables the square output |
| msb_direct_i | input | 1 | 1: square is the code MSB, 0: the MSB divided by two |
| dac_code_o | output | 10 | offset-binary converter code |
| sq_o | output | 1 | square output |

## Verification
The assertions check on every cycle that a sleeping clock leaves both outputs unchanged. They also check that eight consecutive cleared samples give midscale with the square output low, and that eight consecutive samples without the square enable give a low square output. The sample-by-sample shape of the waveforms can only be shown by the bench's scenarios. That covers the bank selection, accumulator wrap, the 8-clock alignment after clear and sleep, and the divide-by-two toggle sequence. The bench compares each code against a separately computed sine or triangle.

// File: rtl/dds_nco_pkg.sv
`timescale 1ns/1ps
package dds_nco_pkg;

  // Output-shaping controls that travel with each sample.
  typedef struct packed {
    logic tri_mode;
    logic bit_out;
    logic msb_direct;
  } wave_cfg_t;

  // Quarter-wave magnitude for index idx of a 2^qw entry table.
  // sin(pi/2 * x) is evaluated as an odd polynomial in Q30 fixed point.
  // The result is scaled to 2^mw - 1 and rounded.
  function automatic int quarter_sine(input int idx, input int qw, input int mw);
    longint x, x2, t, s, amp;
    x   = longint'(idx) <<< (30 - qw);
    x2  = (x * x) >>> 30;
    t   = 64'sd85569278 - ((64'sd5026937 * x2) >>> 30);
    t   = 64'sd693598674 - ((t * x2) >>> 30);
    t   = 64'sd1686629713 - ((t * x2) >>> 30);
    s   = (t * x) >>> 30;
    amp = (longint'(1) <<< mw) - 1;
    return int'((s * amp + (longint'(1) <<< 29)) >>> 30);
  endfunction

endpackage

// File: rtl/nco_delay.sv
`timescale 1ns/1ps
// Enable-gated shift line that carries sideband bits alongside a pipeline.
module nco_delay #(
  parameter int W = 1,
  parameter int D = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [D];

  for (genvar g = 0; g < D; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  st[0] <= '0;
        else if (en) st[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  st[g] <= '0;
        else if (en) st[g] <= st[g-1];
      end
    end
  end

  assign q = st[D-1];
endmodule

// File: rtl/nco_phase_path.sv
`timescale 1ns/1ps
// Stages 1..3: bank select, accumulate, offset add and truncation.
module nco_phase_path
  import dds_nco_pkg::*;
#(
  parameter int ACC_W = 28,
  parameter int PH_W  = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [ACC_W-1:0] freq_a,
  input  logic [ACC_W-1:0] freq_b,
  input  logic [PH_W-1:0]  ofs_a,
  input  logic [PH_W-1:0]  ofs_b,
  input  logic             freq_sel,
  input  logic             ofs_sel,
  input  logic             clr,
  input  wave_cfg_t        cfg,
  output logic [PH_W-1:0]  ph_o,
  output wave_cfg_t        cfg_o,
  output logic             clr_o
);
  localparam int CW = $bits(wave_cfg_t);

  logic [ACC_W-1:0] fw1, acc;
  logic [PH_W-1:0]  po1, po2;
  logic             clr1;
  logic [CW-1:0]    cfg_q;

  // stage 1: bank selection registered so the adder sees a flop
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fw1  <= '0;
      po1  <= '0;
      clr1 <= 1'b0;
    end else if (en) begin
      fw1  <= freq_sel ? freq_b : freq_a;
      po1  <= ofs_sel ? ofs_b : ofs_a;
      clr1 <= clr;
    end
  end

  // stage 2: accumulator (R1), cleared by the sampled clear (R6)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0;
      po2 <= '0;
    end else if (en) begin
      acc <= clr1 ? '0 : acc + fw1;
      po2 <= po1;
    end
  end

  // stage 3: offset onto the top bits, truncated phase (R2)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  ph_o <= '0;
    else if (en) ph_o <= acc[ACC_W-1 -: PH_W] + po2;
  end

  nco_delay #(.W(1), .D(2)) u_clr_dly (
    .clk(clk), .rst_n(rst_n), .en(en), .d(clr1), .q(clr_o)
  );

  nco_delay #(.W(CW), .D(3)) u_cfg_dly (
    .clk(clk), .rst_n(rst_n), .en(en), .d(cfg), .q(cfg_q)
  );
  assign cfg_o = cfg_q;
endmodule

// File: rtl/nco_shaper.sv
`timescale 1ns/1ps
// Stages 4..6: quarter-wave folding, table lookup, triangle, code select.
module nco_shaper
  import dds_nco_pkg::*;
#(
  parameter int PH_W  = 12,
  parameter int AMP_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [PH_W-1:0]  ph_i,
  input  wave_cfg_t        cfg_i,
  input  logic             clr_i,
  output logic [AMP_W-1:0] code_o,
  output wave_cfg_t        cfg_o,
  output logic             clr_o
);
  localparam int QW    = PH_W - 2;
  localparam int QN    = 1 << QW;
  localparam int MAG_W = AMP_W - 1;
  localparam int FW    = PH_W - 1;
  localparam int CW    = $bits(wave_cfg_t);
  localparam logic [AMP_W-1:0] MID = AMP_W'(1) << (AMP_W - 1);

  // quarter-wave table, computed at elaboration
  logic [MAG_W-1:0] qtab [QN];
  for (genvar g = 0; g < QN; g++) begin : g_tab
    assign qtab[g] = MAG_W'(quarter_sine(g, QW, MAG_W));
  end

  // triangle fold (R3)
  logic [FW-1:0]    fold;
  logic [AMP_W-1:0] tri_c;
  assign fold = ph_i[PH_W-1] ? ~ph_i[FW-1:0] : ph_i[FW-1:0];
  if (FW >= AMP_W) begin : g_tri_trunc
    assign tri_c = fold[FW-1 -: AMP_W];
  end else begin : g_tri_pad
    assign tri_c = {fold, {(AMP_W-FW){1'b0}}};
  end

  logic [QW-1:0]    idx4;
  logic             neg4, neg5;
  logic [AMP_W-1:0] tri4, tri5;
  logic [MAG_W-1:0] mag5;
  logic [CW-1:0]    cfg_q;
  wave_cfg_t        cfg5;

  // stage 4: mirror index for quadrants 1 and 3 (R4)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx4 <= '0;
      neg4 <= 1'b0;
      tri4 <= '0;
    end else if (en) begin
      idx4 <= ph_i[QW] ? ~ph_i[QW-1:0] : ph_i[QW-1:0];
      neg4 <= ph_i[PH_W-1];
      tri4 <= tri_c;
    end
  end

  // stage 5: table lookup
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mag5 <= '0;
      neg5 <= 1'b0;
      tri5 <= '0;
    end else if (en) begin
      mag5 <= qtab[idx4];
      neg5 <= neg4;
      tri5 <= tri4;
    end
  end

  // stage 6: offset-binary code, sine or triangle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_o <= '0;
    end else if (en) begin
      if (cfg5.tri_mode) code_o <= tri5;
      else if (neg5)     code_o <= MID - AMP_W'(mag5);
      else               code_o <= MID + AMP_W'(mag5);
    end
  end

  nco_delay #(.W(CW), .D(2)) u_cfg_mid (
    .clk(clk), .rst_n(rst_n), .en(en), .d(cfg_i), .q(cfg_q)
  );
  assign cfg5 = cfg_q;

  logic [CW-1:0] cfg6_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cfg6_q <= '0;
    else if (en) cfg6_q <= cfg_q;
  end
  assign cfg_o = cfg6_q;

  nco_delay #(.W(1), .D(3)) u_clr_dly (
    .clk(clk), .rst_n(rst_n), .en(en), .d(clr_i), .q(clr_o)
  );
endmodule

// File: rtl/nco_out_stage.sv
`timescale 1ns/1ps
// Stages 7..8: MSB tap, divide-by-two toggle, midscale forcing, output flops.
module nco_out_stage
  import dds_nco_pkg::*;
#(
  parameter int AMP_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [AMP_W-1:0] code_i,
  input  wave_cfg_t        cfg_i,
  input  logic             clr_i,
  output logic [AMP_W-1:0] dac_o,
  output logic             sq_o
);
  localparam logic [AMP_W-1:0] MID = AMP_W'(1) << (AMP_W - 1);

  logic [AMP_W-1:0] code7;
  logic             msb7, tog7, clr7;
  wave_cfg_t        cfg7;
  logic             msb_now;

  assign msb_now = code_i[AMP_W-1];

  // stage 7: toggle flips on each rising MSB (R9)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code7 <= '0;
      msb7  <= 1'b0;
      tog7  <= 1'b0;
      clr7  <= 1'b0;
      cfg7  <= '0;
    end else if (en) begin
      code7 <= code_i;
      msb7  <= msb_now;
      tog7  <= clr_i ? 1'b0 : (tog7 ^ (msb_now & ~msb7));
      clr7  <= clr_i;
      cfg7  <= cfg_i;
    end
  end

  // stage 8: output flops (R6, R8, R10, R11)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dac_o <= MID;
      sq_o  <= 1'b0;
    end else if (en) begin
      dac_o <= clr7 ? MID : code7;
      if (!clr7 && cfg7.bit_out && !cfg7.tri_mode)
        sq_o <= cfg7.msb_direct ? msb7 : tog7;
      else
        sq_o <= 1'b0;
    end
  end
endmodule

// File: rtl/dds_nco_core.sv
`timescale 1ns/1ps
module dds_nco_core
  import dds_nco_pkg::*;
#(
  parameter int ACC_W = 28,
  parameter int PH_W  = 12,
  parameter int AMP_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ACC_W-1:0] freq_a_i,
  input  logic [ACC_W-1:0] freq_b_i,
  input  logic [PH_W-1:0]  ofs_a_i,
  input  logic [PH_W-1:0]  ofs_b_i,
  input  logic             freq_sel_i,
  input  logic             ofs_sel_i,
  input  logic             acc_clear_i,
  input  logic             clk_sleep_i,
  input  logic             tri_mode_i,
  input  logic             bit_out_i,
  input  logic             msb_direct_i,
  output logic [AMP_W-1:0] dac_code_o,
  output logic             sq_o
);
  // a single stage enable: sleep freezes the whole pipeline (R7)
  logic en;
  assign en = ~clk_sleep_i;

  wave_cfg_t        cfg_in, cfg3, cfg6;
  logic [PH_W-1:0]  ph3;
  logic             clr3, clr6;
  logic [AMP_W-1:0] code6;

  assign cfg_in = '{tri_mode: tri_mode_i, bit_out: bit_out_i, msb_direct: msb_direct_i};

  nco_phase_path #(.ACC_W(ACC_W), .PH_W(PH_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .en(en),
    .freq_a(freq_a_i), .freq_b(freq_b_i),
    .ofs_a(ofs_a_i), .ofs_b(ofs_b_i),
    .freq_sel(freq_sel_i), .ofs_sel(ofs_sel_i),
    .clr(acc_clear_i), .cfg(cfg_in),
    .ph_o(ph3), .cfg_o(cfg3), .clr_o(clr3)
  );

  nco_shaper #(.PH_W(PH_W), .AMP_W(AMP_W)) u_shape (
    .clk(clk), .rst_n(rst_n), .en(en),
    .ph_i(ph3), .cfg_i(cfg3), .clr_i(clr3),
    .code_o(code6), .cfg_o(cfg6), .clr_o(clr6)
  );

  nco_out_stage #(.AMP_W(AMP_W)) u_out (
    .clk(clk), .rst_n(rst_n), .en(en),
    .code_i(code6), .cfg_i(cfg6), .clr_i(clr6),
    .dac_o(dac_code_o), .sq_o(sq_o)
  );
endmodule

// File: rtl/dds_nco_chk.sv
`timescale 1ns/1ps
module dds_nco_chk #(
  parameter int AMP_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             acc_clear_i,
  input logic             clk_sleep_i,
  input logic             tri_mode_i,
  input logic             bit_out_i,
  input logic [AMP_W-1:0] dac_code_o,
  input logic             sq_o
);
  localparam logic [AMP_W-1:0] MID = AMP_W'(1) << (AMP_W - 1);

  // runs of consecutive enabled samples, saturating at 15
  logic [3:0] clr_run, quiet_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clr_run   <= '0;
      quiet_run <= '0;
    end else if (!clk_sleep_i) begin
      clr_run   <= !acc_clear_i ? 4'd0 : ((clr_run == 4'd15) ? clr_run : clr_run + 4'd1);
      quiet_run <= (bit_out_i && !tri_mode_i) ? 4'd0
                 : ((quiet_run == 4'd15) ? quiet_run : quiet_run + 4'd1);
    end
  end

  p_clear_mid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_run >= 4'd8) |-> (dac_code_o == MID));

  p_clear_sq_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_run >= 4'd8) |-> !sq_o);

  p_sq_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet_run >= 4'd8) |-> !sq_o);

  p_sleep_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clk_sleep_i |=> $stable(dac_code_o));

  p_sleep_sq_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clk_sleep_i |=> $stable(sq_o));
endmodule

bind dds_nco_core dds_nco_chk #(.AMP_W(AMP_W)) u_chk (.*);

// File: tb/sim_dds_nco_core.sv
`timescale 1ns/1ps
module sim_dds_nco_core;
  localparam real HALF_PI = 1.5707963267948966;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [27:0] freq_a = '0, freq_b = '0;
  logic [11:0] ofs_a = '0, ofs_b = '0;
  logic        fsel = 1'b0, psel = 1'b0, clr = 1'b0, sleep = 1'b0;
  logic        tri_m = 1'b0, bo = 1'b0, dir = 1'b0;
  logic [9:0]  dac;
  logic        sq;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dds_nco_core u0 (
    .clk(clk), .rst_n(rst_n),
    .freq_a_i(freq_a), .freq_b_i(freq_b),
    .ofs_a_i(ofs_a), .ofs_b_i(ofs_b),
    .freq_sel_i(fsel), .ofs_sel_i(psel),
    .acc_clear_i(clr), .clk_sleep_i(sleep),
    .tri_mode_i(tri_m), .bit_out_i(bo), .msb_direct_i(dir),
    .dac_code_o(dac), .sq_o(sq)
  );

  // scoreboard queues
  int    q_code[$], q_tol[$], q_sq[$];
  string q_tag[$], q_sqtag[$];
  bit    pushed = 1'b0;

  // reference state
  logic [27:0] acc_m = '0;
  logic [11:0] ph_m;
  logic [10:0] fold_m;
  logic [9:0]  idx_m, tri_v;
  int          mag_m, code_m, sine_m;
  bit          msb_m, pm = 1'b0, tog = 1'b0;

  task automatic check(string tag, int act, int exp, int tol);
    checks++;
    if (act - exp > tol || exp - act > tol) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // driver side: one expected item per enabled edge (R1, R2, R5)
  task automatic drive_expect();
    acc_m  = clr ? 28'd0 : acc_m + (fsel ? freq_b : freq_a);
    ph_m   = acc_m[27:16] + (psel ? ofs_b : ofs_a);
    fold_m = ph_m[11] ? ~ph_m[10:0] : ph_m[10:0];
    tri_v  = fold_m[10:1];
    idx_m  = ph_m[10] ? ~ph_m[9:0] : ph_m[9:0];
    mag_m  = (idx_m == 0) ? 0 : $rtoi(511.0 * $sin(HALF_PI * real'(idx_m) / 1024.0) + 0.5);
    sine_m = ph_m[11] ? 512 - mag_m : 512 + mag_m;
    if (tri_m) begin
      code_m = int'(tri_v);
      msb_m  = tri_v[9];
    end else begin
      code_m = sine_m;
      msb_m  = !ph_m[11] || (idx_m == 0);
    end
    tog = clr ? 1'b0 : (tog ^ (msb_m & !pm));
    pm  = msb_m;
    if (clr) begin
      q_code.push_back(512); q_tol.push_back(0); q_tag.push_back("R6 clear midscale");
    end else if (tri_m) begin
      q_code.push_back(code_m); q_tol.push_back(0); q_tag.push_back("R3 triangle (R1 R2 R5)");
    end else begin
      q_code.push_back(code_m); q_tol.push_back(2); q_tag.push_back("R4 sine (R1 R2 R5)");
    end
    if (!clr && bo && !tri_m) begin
      q_sq.push_back(dir ? int'(msb_m) : int'(tog));
      q_sqtag.push_back(dir ? "R8 square direct" : "R9 square halved");
    end else begin
      q_sq.push_back(0);
      q_sqtag.push_back(clr ? "R6 square low" : "R10 square off");
    end
    pushed = 1'b1;
  endtask

  always @(posedge clk) begin
    if (rst_n && !sleep) drive_expect();
  end

  // monitor: sample 7 enabled edges old appears now
  always @(negedge clk) begin
    if (pushed) begin
      pushed = 1'b0;
      if (q_code.size() >= 8) begin
        int e, t, s;
        string tg, st;
        e = q_code.pop_front(); t = q_tol.pop_front(); tg = q_tag.pop_front();
        s = q_sq.pop_front(); st = q_sqtag.pop_front();
        check(tg, int'(dac), e, t);
        check(st, int'(sq), s, 0);
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int hold_d, hold_s;
    // R11: reset state
    tick(3);
    check("R11 reset code", int'(dac), 512, 0);
    check("R11 reset square", int'(sq), 0, 0);
    rst_n = 1'b1;

    // R6: clear held, then release with a triangle
    clr = 1'b1; tri_m = 1'b1; freq_a = 28'h0100000;
    tick(12);
    check("R6 held clear", int'(dac), 512, 0);
    clr = 1'b0;
    tick(300);

    // R1 R2 R4: bank 1 sine with bank 1 offset
    tri_m = 1'b0; fsel = 1'b1; psel = 1'b1;
    freq_b = 28'h0123457; ofs_b = 12'h400; ofs_a = 12'h0AB;
    tick(400);

    // R1: wrap with a tuning word near full scale, bank 0 offset
    fsel = 1'b0; psel = 1'b0; freq_a = 28'hFFF0001;
    tick(120);

    // R8 then R9: square output
    freq_a = 28'h0400000; bo = 1'b1; dir = 1'b1;
    tick(200);
    dir = 1'b0;
    tick(300);

    // R10: reserved combination, then disabled
    tri_m = 1'b1;
    tick(100);
    tri_m = 1'b0; bo = 1'b0;
    tick(60);

    // R7: sleep holds outputs while inputs move
    bo = 1'b1; dir = 1'b1;
    tick(40);
    sleep = 1'b1;
    hold_d = int'(dac); hold_s = int'(sq);
    for (int i = 0; i < 20; i++) begin
      if (i == 3) begin freq_a = 28'h0A00000; ofs_a = 12'h800; end
      tick(1);
      check("R7 sleep code hold", int'(dac), hold_d, 0);
      check("R7 sleep square hold", int'(sq), hold_s, 0);
    end
    sleep = 1'b0;
    tick(100);

    // R6: clear in sine mode with square enabled, release
    clr = 1'b1;
    tick(20);
    clr = 1'b0;
    tick(80);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog R5 actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule